// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Register Bus

This block collects a parameterized set of system interrupt inputs (up to 64) and drives one host interrupt line. Each input is synchronized through two flops. It is then classified as rising-edge, falling-edge, active-high level or active-low level, and recorded in a per-input pending bit. The block combines the pending bits with per-input enable bits, a global enable and a host enable. A prioritized-index register names the most urgent pending and enabled input.

Firmware programs the block through a plain 32-bit register bus with byte write strobes and combinational read data. Three index registers take an interrupt number and set or clear a single bit. The first clears a pending bit, which is the acknowledge. The other two set or clear an enable bit. Bulk clear words clear many pending or enable bits at once. Each input has an 8-bit channel number. The lowest channel number wins, and a tie goes to the lowest interrupt number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all pending, enable, polarity, type, channel, global-enable and host-enable state is 0 and `host_irq` is 0. A read of the prioritized index (0x80) returns 0x8000_0000. Reads of control 0x04, host control 0x0C and any unmapped offset return 0.
- R2: With polarity=1 and type=1, a 0-to-1 transition of an input sets its pending bit after the two-flop synchronizer. The bit stays set after the input falls, until it is cleared.
- R3: With polarity=0 and type=1, only a 1-to-0 transition sets the pending bit. A rising transition does not.
- R4: With type=0, the pending bit is set on every cycle in which the synchronized input is at its active level (high for polarity=1, low for polarity=0). An acknowledge has no lasting effect while that level remains.
- R5: A write of N to 0x24 with strobe bit 0 set clears only pending bit N. The write is ignored when N >= the input count or when strobe bit 0 is clear.
- R6: Writes of N to 0x28 and 0x2C (strobe bit 0 set) set and clear enable bit N. A write to bulk word 0x380+4k clears enable bit 32k+j for every data bit j written as 1, but only within bytes whose strobe is set.
- R7: A write to bulk word 0x280+4k clears pending bit 32k+j for every data bit j written as 1, but only within bytes whose strobe is set.
- R8: `host_irq` is 1 exactly when global enable (0x10 bit 0) is 1, host enable bit 0 is 1 and at least one input is both pending and enabled. Host enable bit 0 is written at 0x1500 bit 0, or set and cleared by writing 0 to 0x34 and 0x38. Index values other than 0 are ignored there.
- R9: The read at 0x80 returns the winner in bits 9:0, with bit 31 = 0, when any input is pending and enabled. Otherwise it returns bit 31 = 1 and index 0. The global and host enables do not gate this register. The winner has the lowest channel number, and a tie goes to the lowest interrupt number.
- R10: Channel word 0x400+4k holds the channel of input 4k+b in byte b. Polarity word 0xD00+4k and type word 0xD80+4k hold input 32k+j in bit j. All of these read back as written, and only the bytes whose strobe is set are updated.
- R11: When an input event and a clear of the same pending bit land in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IN | Asynchronous system interrupt inputs |
| bus_wr | input | 1 | Write cycle qualifier |
| bus_addr | input | 13 | Byte address (word aligned) |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| host_irq | output | 1 | Host interrupt request |

## Verification
Several properties are checked on every cycle:
- The host line is only ever high behind both enables and a pending, enabled input.
- The none-pending flag agrees with the pending and enable state.
- The reported winner is pending and enabled, and no other candidate beats it on channel or index.
- Pending bits only fall on a clear request, and an active level always sets its pending bit.

Only the bench scenarios can show the parts that depend on bus decoding. These are strobe handling, ignored out-of-range indices, bulk-word bit placement, the falling-edge and active-low classifications, and the same-cycle event-versus-acknowledge race. The bench also compares randomized channel maps and pending patterns against its own winner model.

// File: rtl/prio_irq_pkg.sv
// Package: shared constants for the prioritized interrupt controller.
// Assumes a 13-bit byte address bus. Word addresses are byte offsets / 4.
package prio_irq_pkg;
    localparam int ADDR_W  = 13;
    localparam int WORD_AW = ADDR_W - 2;
    localparam int IDX_W   = 10;
    localparam int CH_W    = 8;

    // word addresses of single registers
    localparam int WA_GLOBAL_EN   = 'h010 >> 2;
    localparam int WA_ACK_IDX     = 'h024 >> 2;
    localparam int WA_EN_IDX_SET  = 'h028 >> 2;
    localparam int WA_EN_IDX_CLR  = 'h02C >> 2;
    localparam int WA_HEN_IDX_SET = 'h034 >> 2;
    localparam int WA_HEN_IDX_CLR = 'h038 >> 2;
    localparam int WA_PRIO_IDX    = 'h080 >> 2;
    localparam int WA_HOST_EN     = 'h1500 >> 2;

    // word addresses of array bases
    localparam int WA_PEND_CLR_BASE = 'h280 >> 2;
    localparam int WA_EN_CLR_BASE   = 'h380 >> 2;
    localparam int WA_CHAN_BASE     = 'h400 >> 2;
    localparam int WA_POL_BASE      = 'hD00 >> 2;
    localparam int WA_TYPE_BASE     = 'hD80 >> 2;
endpackage

// File: rtl/prio_irq_capture.sv
// Module: per-input synchronizer, event classifier and pending latch.
// Assumes irq_in is asynchronous. The pending bit sets on the configured
// edge or level. A set in the same cycle as a clear request wins.
module prio_irq_capture #(
    parameter int NUM_IN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [NUM_IN-1:0] pol_q,
    input  logic [NUM_IN-1:0] typ_q,
    input  logic [NUM_IN-1:0] pend_clr,
    output logic [NUM_IN-1:0] pend_q,
    output logic [NUM_IN-1:0] lvl_hit
);
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic sync_a, sync_b, sync_prev;
        logic at_level, edge_seen, event_hit;

        // Purpose: two-flop synchronizer plus a delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_a    <= 1'b0;
                sync_b    <= 1'b0;
                sync_prev <= 1'b0;
            end else begin
                sync_a    <= irq_in[i];
                sync_b    <= sync_a;
                sync_prev <= sync_b;
            end
        end

        // Purpose: classify the synchronized input per polarity and type.
        always_comb begin
            at_level  = pol_q[i] ? sync_b : ~sync_b;
            edge_seen = pol_q[i] ? (sync_b & ~sync_prev) : (~sync_b & sync_prev);
            event_hit = typ_q[i] ? edge_seen : at_level;
        end

        assign lvl_hit[i] = ~typ_q[i] & at_level;

        // Purpose: pending latch; a new event beats a simultaneous clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (event_hit)
                pend_q[i] <= 1'b1;
            else if (pend_clr[i])
                pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/prio_irq_resolve.sv
// Module: combinational winner selection among pending and enabled inputs.
// The lowest channel number wins, and a tie goes to the lowest index.
// Assumes NUM_IN <= 2**IDX_W.
module prio_irq_resolve
    import prio_irq_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input  logic [NUM_IN-1:0]      cand,
    input  logic [NUM_IN*CH_W-1:0] chan_q,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx
);
    logic [CH_W-1:0] best_ch;

    // Purpose: ascending scan; a strict compare keeps the lower index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_ch   = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (cand[i] && (!win_valid || chan_q[i*CH_W +: CH_W] < best_ch)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_ch   = chan_q[i*CH_W +: CH_W];
            end
        end
    end
endmodule

// File: rtl/prio_irq_regs.sv
// Module: register bus decode, configuration storage and read mux.
// Writes take effect on the clock edge. Reads are combinational on bus_addr.
// Index registers act only with strobe bit 0. Word registers honour byte strobes.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    input  logic                   win_valid,
    input  logic [IDX_W-1:0]       win_idx,
    output logic [NUM_IN-1:0]      en_q,
    output logic [NUM_IN-1:0]      pol_q,
    output logic [NUM_IN-1:0]      typ_q,
    output logic [NUM_IN-1:0]      pend_clr,
    output logic [NUM_IN*CH_W-1:0] chan_q,
    output logic                   glb_q,
    output logic                   hen_q,
    output logic [31:0]            bus_rdata
);
    localparam int NW  = (NUM_IN + 31) / 32;
    localparam int CMW = (NUM_IN + 3) / 4;

    localparam logic [WORD_AW-1:0] A_GLB   = WORD_AW'(WA_GLOBAL_EN);
    localparam logic [WORD_AW-1:0] A_ACK   = WORD_AW'(WA_ACK_IDX);
    localparam logic [WORD_AW-1:0] A_ENS   = WORD_AW'(WA_EN_IDX_SET);
    localparam logic [WORD_AW-1:0] A_ENC   = WORD_AW'(WA_EN_IDX_CLR);
    localparam logic [WORD_AW-1:0] A_HENS  = WORD_AW'(WA_HEN_IDX_SET);
    localparam logic [WORD_AW-1:0] A_HENC  = WORD_AW'(WA_HEN_IDX_CLR);
    localparam logic [WORD_AW-1:0] A_PRIO  = WORD_AW'(WA_PRIO_IDX);
    localparam logic [WORD_AW-1:0] A_HEN   = WORD_AW'(WA_HOST_EN);

    logic [WORD_AW-1:0] waddr;
    logic [IDX_W-1:0]   widx;
    logic               idx_wr;
    logic               addr_lo_unused;
    logic [NW*32-1:0]   pol_pad, typ_pad;
    logic [CMW*32-1:0]  chan_pad;

    assign waddr          = bus_addr[ADDR_W-1:2];
    assign widx           = bus_wdata[IDX_W-1:0];
    assign idx_wr         = bus_wr && bus_be[0];
    assign addr_lo_unused = ^bus_addr[1:0];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        localparam int WK  = i / 32;
        localparam int BT  = i % 32;
        localparam int BY  = BT / 8;
        localparam int CWD = i / 4;
        localparam int CBY = i % 4;
        localparam logic [WORD_AW-1:0] A_PCLR = WORD_AW'(WA_PEND_CLR_BASE + WK);
        localparam logic [WORD_AW-1:0] A_ECLR = WORD_AW'(WA_EN_CLR_BASE + WK);
        localparam logic [WORD_AW-1:0] A_POL  = WORD_AW'(WA_POL_BASE + WK);
        localparam logic [WORD_AW-1:0] A_TYP  = WORD_AW'(WA_TYPE_BASE + WK);
        localparam logic [WORD_AW-1:0] A_CH   = WORD_AW'(WA_CHAN_BASE + CWD);
        localparam logic [IDX_W-1:0]   MY_IDX = IDX_W'(i);

        logic bulk_lane, en_set, en_clr;

        assign bulk_lane = bus_wr && bus_be[BY] && bus_wdata[BT];
        assign en_set    = idx_wr && waddr == A_ENS && widx == MY_IDX;
        assign en_clr    = (idx_wr && waddr == A_ENC && widx == MY_IDX) ||
                           (bulk_lane && waddr == A_ECLR);
        assign pend_clr[i] = (idx_wr && waddr == A_ACK && widx == MY_IDX) ||
                             (bulk_lane && waddr == A_PCLR);

        // Purpose: enable bit, updated by index set/clear and bulk clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (en_set)
                en_q[i] <= 1'b1;
            else if (en_clr)
                en_q[i] <= 1'b0;
        end

        // Purpose: polarity and type bits from their strobed word lanes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol_q[i] <= 1'b0;
                typ_q[i] <= 1'b0;
            end else if (bus_wr && bus_be[BY]) begin
                if (waddr == A_POL) pol_q[i] <= bus_wdata[BT];
                if (waddr == A_TYP) typ_q[i] <= bus_wdata[BT];
            end
        end

        // Purpose: channel byte for this input, one byte lane per input.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chan_q[i*CH_W +: CH_W] <= '0;
            else if (bus_wr && bus_be[CBY] && waddr == A_CH)
                chan_q[i*CH_W +: CH_W] <= bus_wdata[CBY*8 +: CH_W];
        end
    end

    // Purpose: global enable and host enable bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= 1'b0;
            hen_q <= 1'b0;
        end else begin
            if (idx_wr && waddr == A_GLB) glb_q <= bus_wdata[0];
            if (idx_wr && waddr == A_HEN) hen_q <= bus_wdata[0];
            if (idx_wr && waddr == A_HENS && widx == '0) hen_q <= 1'b1;
            if (idx_wr && waddr == A_HENC && widx == '0) hen_q <= 1'b0;
        end
    end

    assign pol_pad  = (NW*32)'(pol_q);
    assign typ_pad  = (NW*32)'(typ_q);
    assign chan_pad = (CMW*32)'(chan_q);

    // Purpose: combinational read mux; unmapped words return 0.
    always_comb begin
        bus_rdata = '0;
        if (waddr == A_GLB) bus_rdata[0] = glb_q;
        if (waddr == A_HEN) bus_rdata[0] = hen_q;
        if (waddr == A_PRIO)
            bus_rdata = {~win_valid, {(31-IDX_W){1'b0}}, win_valid ? win_idx : {IDX_W{1'b0}}};
        for (int k = 0; k < NW; k++) begin
            if (waddr == WORD_AW'(WA_POL_BASE + k))  bus_rdata = pol_pad[k*32 +: 32];
            if (waddr == WORD_AW'(WA_TYPE_BASE + k)) bus_rdata = typ_pad[k*32 +: 32];
        end
        for (int k = 0; k < CMW; k++) begin
            if (waddr == WORD_AW'(WA_CHAN_BASE + k)) bus_rdata = chan_pad[k*32 +: 32];
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the prioritized interrupt controller.
// Joins bus registers, input capture and priority resolution, and gates the
// host line by global and host enables. Assumes 1 <= NUM_IN <= 64.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              host_irq
);
    logic [NUM_IN-1:0]      en_q, pol_q, typ_q, pend_clr, pend_q, lvl_hit, cand;
    logic [NUM_IN*CH_W-1:0] chan_q;
    logic                   glb_q, hen_q, win_valid;
    logic [IDX_W-1:0]       win_idx;

    prio_irq_regs #(.NUM_IN(NUM_IN)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .win_valid(win_valid),
        .win_idx(win_idx), .en_q(en_q), .pol_q(pol_q), .typ_q(typ_q),
        .pend_clr(pend_clr), .chan_q(chan_q), .glb_q(glb_q), .hen_q(hen_q),
        .bus_rdata(bus_rdata)
    );

    prio_irq_capture #(.NUM_IN(NUM_IN)) cap_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_q(pol_q),
        .typ_q(typ_q), .pend_clr(pend_clr), .pend_q(pend_q), .lvl_hit(lvl_hit)
    );

    assign cand = pend_q & en_q;

    prio_irq_resolve #(.NUM_IN(NUM_IN)) res_i (
        .cand(cand), .chan_q(chan_q), .win_valid(win_valid), .win_idx(win_idx)
    );

    // Purpose: host line gated by both enables.
    assign host_irq = glb_q & hen_q & (|cand);
endmodule

// File: rtl/prio_irq_chk.sv
// Module: assertion checker bound to prio_irq_ctrl.
// Observes the pending, enable and winner state and the host line.
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_irq,
    input logic                   glb_q,
    input logic                   hen_q,
    input logic [NUM_IN-1:0]      pend_q,
    input logic [NUM_IN-1:0]      en_q,
    input logic [NUM_IN-1:0]      pend_clr,
    input logic [NUM_IN-1:0]      lvl_hit,
    input logic [NUM_IN*CH_W-1:0] chan_q,
    input logic                   win_valid,
    input logic [IDX_W-1:0]       win_idx
);
    logic [NUM_IN-1:0] live;
    logic [CH_W-1:0]   win_ch;
    logic              beaten;

    assign live = pend_q & en_q;

    // Purpose: look for any candidate that should have beaten the winner.
    always_comb begin
        win_ch = '0;
        for (int j = 0; j < NUM_IN; j++)
            if (IDX_W'(j) == win_idx) win_ch = chan_q[j*CH_W +: CH_W];
        beaten = 1'b0;
        for (int j = 0; j < NUM_IN; j++)
            if (live[j] && (chan_q[j*CH_W +: CH_W] < win_ch ||
                (chan_q[j*CH_W +: CH_W] == win_ch && IDX_W'(j) < win_idx)))
                beaten = 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && !host_irq));

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(pend_clr)) & ~pend_q) == '0));

    p_level_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lvl_hit) & ~pend_q) == '0));

    p_host_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (glb_q && hen_q && win_valid));

    p_none_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid == (|live));

    p_win_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (|((live >> win_idx) & NUM_IN'(1))));

    p_win_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !beaten);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_IN(NUM_IN)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .glb_q(glb_q),
    .hen_q(hen_q), .pend_q(pend_q), .en_q(en_q), .pend_clr(pend_clr),
    .lvl_hit(lvl_hit), .chan_q(chan_q), .win_valid(win_valid), .win_idx(win_idx)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] ch_m [N];

    prio_irq_ctrl #(.NUM_IN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .host_irq(host_irq)
    );

    always #10 clk = ~clk;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input string tag, input logic [12:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check32(tag, d, exp);
    endtask

    task automatic check_prio(input string tag, input int win);
        check_rd(tag, 13'h080, (win < 0) ? 32'h8000_0000 : 32'(win));
    endtask

    task automatic check_host(input string tag, input logic exp);
        @(negedge clk);
        check32(tag, {31'b0, host_irq}, {31'b0, exp});
    endtask

    task automatic pulse(input logic [N-1:0] pat);
        @(negedge clk) irq_in = pat;
        wait_cyc(4);
        irq_in = '0;
        wait_cyc(4);
    endtask

    task automatic clear_all();
        wr(13'h280, 32'hFFFF_FFFF, 4'hF);
        wr(13'h284, 32'hFFFF_FFFF, 4'hF);
        wr(13'h380, 32'hFFFF_FFFF, 4'hF);
        wr(13'h384, 32'hFFFF_FFFF, 4'hF);
    endtask

    function automatic int model_win(input logic [N-1:0] live);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (live[i] && (best < 0 || ch_m[i] < ch_m[best])) best = i;
        return best;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h00C0_FFEE);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state and unmapped reads
        check_host("R1 host_irq after reset", 1'b0);
        check_prio("R1 prio index none", -1);
        check_rd("R1 global enable", 13'h010, 0);
        check_rd("R1 host enable", 13'h1500, 0);
        check_rd("R1 polarity word", 13'h0D00, 0);
        check_rd("R1 type word", 13'h0D84, 0);
        check_rd("R1 channel word", 13'h0404, 0);
        check_rd("R1 control reads 0", 13'h004, 0);
        check_rd("R1 host control reads 0", 13'h00C, 0);
        check_rd("R1 unmapped reads 0", 13'h0200, 0);

        // R10 strobed writes and readback
        wr(13'h400, 32'h1122_3344, 4'b0101);
        check_rd("R10 channel strobes", 13'h400, 32'h0022_0044);
        wr(13'hD04, 32'hA5A5_5A5A, 4'b1000);
        check_rd("R10 polarity strobes", 13'hD04, 32'hA500_0000);
        wr(13'hD84, 32'h0000_00F0, 4'b0001);
        check_rd("R10 type strobes", 13'hD84, 32'h0000_00F0);

        // configure all inputs as rising edge, channels 0, enables on
        wr(13'h400, 0, 4'hF);
        wr(13'hD00, 32'hFFFF_FFFF, 4'hF);
        wr(13'hD04, 32'hFFFF_FFFF, 4'hF);
        wr(13'hD80, 32'hFFFF_FFFF, 4'hF);
        wr(13'hD84, 32'hFFFF_FFFF, 4'hF);
        clear_all();
        wr(13'h010, 1, 4'h1);
        wr(13'h034, 0, 4'h1);
        check_rd("R8 host enable via index", 13'h1500, 1);

        // R2 rising edge captured and held
        pulse(N'(1) << 5);
        check_prio("R6 pending but not enabled", -1);
        wr(13'h028, 5, 4'h1);
        check_prio("R2 rising edge pending", 5);
        check_host("R8 host asserted", 1'b1);

        // R5 acknowledge by index
        wr(13'h024, 5, 4'h1);
        check_prio("R5 ack clears", -1);
        pulse(N'(1) << 3);
        wr(13'h028, 3, 4'h1);
        wr(13'h024, 70, 4'h1);
        check_prio("R5 out-of-range index ignored", 3);
        wr(13'h024, 3, 4'b1110);
        check_prio("R5 strobe 0 clear ignored", 3);
        wr(13'h024, 3, 4'h1);
        check_prio("R5 ack of 3", -1);

        // R3 falling edge only
        wr(13'hD00, 32'hFFFF_FF7F, 4'hF);
        wr(13'h028, 7, 4'h1);
        @(negedge clk) irq_in[7] = 1'b1;
        wait_cyc(4);
        check_prio("R3 rising ignored on falling type", -1);
        irq_in[7] = 1'b0;
        wait_cyc(4);
        check_prio("R3 falling edge pending", 7);
        wr(13'h024, 7, 4'h1);
        wr(13'hD00, 32'hFFFF_FFFF, 4'hF);
        check_prio("R3 cleared", -1);

        // R4 level types
        wr(13'hD80, ~(32'h1 << 9), 4'hF);
        wr(13'h028, 9, 4'h1);
        @(negedge clk) irq_in[9] = 1'b1;
        wait_cyc(4);
        check_prio("R4 active-high pending", 9);
        wr(13'h024, 9, 4'h1);
        wait_cyc(1);
        check_prio("R4 ack no lasting effect", 9);
        irq_in[9] = 1'b0;
        wait_cyc(4);
        wr(13'h024, 9, 4'h1);
        check_prio("R4 ack after level drops", -1);
        wr(13'hD00, ~(32'h1 << 9), 4'hF);
        wait_cyc(2);
        check_prio("R4 active-low pending", 9);
        wr(13'hD80, 32'hFFFF_FFFF, 4'hF);
        wr(13'hD00, 32'hFFFF_FFFF, 4'hF);
        wr(13'h024, 9, 4'h1);
        check_prio("R4 restored", -1);
        clear_all();

        // R6 enable index and bulk clear
        pulse(N'(1) << 2);
        wr(13'h028, 2, 4'h1);
        check_prio("R6 enable set", 2);
        wr(13'h380, 32'h4, 4'b1110);
        check_prio("R6 bulk enable clear unstrobed byte", 2);
        wr(13'h380, 32'h4, 4'b0001);
        check_prio("R6 bulk enable clear", -1);
        wr(13'h028, 2, 4'h1);
        wr(13'h02C, 2, 4'h1);
        check_prio("R6 enable index clear", -1);

        // R7 bulk pending clear
        wr(13'h280, 32'h4, 4'b0001);
        wr(13'h028, 2, 4'h1);
        check_prio("R7 bulk pending clear", -1);
        wr(13'h02C, 2, 4'h1);

        // R8 host gating
        pulse(N'(1) << 40);
        wr(13'h028, 40, 4'h1);
        check_host("R8 host with input 40", 1'b1);
        wr(13'h010, 0, 4'h1);
        check_host("R8 global off", 1'b0);
        check_prio("R9 not gated by global", 40);
        wr(13'h010, 1, 4'h1);
        wr(13'h038, 0, 4'h1);
        check_host("R8 host enable index clear", 1'b0);
        check_rd("R8 host enable readback", 13'h1500, 0);
        wr(13'h1500, 1, 4'h1);
        check_host("R8 host enable word", 1'b1);
        wr(13'h038, 1, 4'h1);
        check_host("R8 host index 1 ignored", 1'b1);
        wr(13'h024, 40, 4'h1);
        check_host("R8 host drops after ack", 1'b0);
        clear_all();

        // R11 event and clear in the same cycle
        wr(13'h028, 12, 4'h1);
        @(negedge clk) irq_in[12] = 1'b1;
        @(negedge clk);
        wr(13'h024, 12, 4'h1);
        wait_cyc(3);
        irq_in[12] = 1'b0;
        check_prio("R11 new event wins over clear", 12);
        clear_all();

        // R9 directed priority
        for (int i = 0; i < N; i++) ch_m[i] = 8'h0;
        wr(13'h414, 32'h3, 4'b0001);
        wr(13'h420, 32'h100, 4'b0010);
        pulse((N'(1) << 20) | (N'(1) << 33));
        wr(13'h028, 20, 4'h1);
        wr(13'h028, 33, 4'h1);
        check_prio("R9 lower channel wins", 33);
        wr(13'h420, 32'h300, 4'b0010);
        check_prio("R9 tie lower index wins", 20);

        // R9 randomized priority
        for (int it = 0; it < 24; it++) begin
            logic [N-1:0] en_v, pat;
            int exp_w;
            clear_all();
            for (int w = 0; w < N / 4; w++) begin
                logic [31:0] v;
                v = $urandom & 32'h0707_0707;
                for (int b = 0; b < 4; b++) ch_m[w*4+b] = v[b*8 +: 8];
                wr(13'(13'h400 + w * 4), v, 4'hF);
            end
            en_v = {$urandom, $urandom} | {$urandom, $urandom};
            pat  = (it == 0) ? '0 : ({$urandom, $urandom} & {$urandom, $urandom});
            for (int i = 0; i < N; i++)
                if (en_v[i]) wr(13'h028, 32'(i), 4'h1);
            pulse(pat);
            exp_w = model_win(pat & en_v);
            check_prio($sformatf("R9 random iteration %0d", it), exp_w);
            check_host($sformatf("R8 random iteration %0d", it), |(pat & en_v));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule